// File: doc/BRIEF.md
# SDRAM Bank Timing Checker

This block watches a stream of already-decoded SDRAM commands and keeps a model of every bank: idle, open, closing (precharge in flight) or open with an automatic close scheduled. Each bank carries its own cycle counters. Every command is judged against the rules that govern bank opening, column access and closing, and the verdict appears one cycle later. A command found illegal leaves the model untouched and produces a one-cycle error pulse with a code that names the broken rule.

The block sits beside a memory controller or a bus monitor. It never issues commands and never touches data. All timing limits are parameters counted in clock cycles. A limit given in nanoseconds is turned into cycles by dividing it by the clock period and rounding up. The defaults fit a 100 MHz clock: row cycle 7, minimum open time 5, open-to-access 2, close time 2, open-to-open across banks 2, write recovery 2, burst length 4.

Top module: `sdram_bank_guard`

## Requirements
- R1: After reset every bank reads idle, `cmd_ok` and `cmd_err` are low and `err_code` is 0. Bank states are reported two bits per bank, bank i at `bank_state[2i+1:2i]`: 0 idle, 1 open, 2 closing, 3 open with an automatic close scheduled.
- R2: Command codes are 1 open (activate), 2 read, 3 write, 4 close (precharge). Codes 0, 5, 6 and 7 are no-operations that are always legal and change nothing. Each cycle with `cmd_vld` high gives exactly one of `cmd_ok` or `cmd_err` on the next cycle. `err_code` is nonzero exactly when `cmd_err` is high, and both stay low after a cycle without `cmd_vld`.
- R3: An open is legal only for an idle bank. Otherwise it is rejected with code 1.
- R4: An open must come at least T_RC cycles after the previous open of the same bank. Otherwise it is rejected with code 2.
- R5: An open must come at least T_RRD cycles after the last accepted open of any bank. Otherwise it is rejected with code 3.
- R6: A read or write to a bank that is not open is rejected with code 4. One issued fewer than T_RCD cycles after that bank's open is rejected with code 5.
- R7: A close with `cmd_a10` high applies to all banks. With `cmd_a10` low it applies only to `cmd_bank`. A close that reaches an idle or closing bank is legal and leaves that bank as it is.
- R8: An accepted close puts an open bank in the closing state for T_RP cycles. An open reaching it during that window is rejected with code 1.
- R9: A close is rejected with code 7 if any bank it would close has been open for fewer than T_RAS cycles. A read or write with auto-close (`cmd_a10` high) is rejected with code 7 if its internal close would begin before T_RAS.
- R10: A read with auto-close issued in cycle t starts the internal close in cycle t+BURST_LEN. A write with auto-close starts it in cycle t+BURST_LEN-1+T_WR. In both cases the bank becomes idle T_RP cycles after the start.
- R11: While a bank is in state 3, a read, write or close that reaches it is rejected with code 6.
- R12: With FULL_PAGE set, every read or write with auto-close is rejected with code 8. Codes 4, 5 and 7 take priority over code 8.
- R13: A rejected command changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_bank | input | BANK_W | Target bank |
| cmd_a10 | input | 1 | Auto-close flag on read/write; all-banks flag on close |
| bank_state | output | 2*NUM_BANKS | Per-bank state, two bits per bank |
| cmd_ok | output | 1 | Previous-cycle command was legal |
| cmd_err | output | 1 | Previous-cycle command was illegal (one-cycle pulse) |
| err_code | output | 4 | Violated rule of the rejected command, 0 otherwise |

## Verification
A wrong bank state or a miscounted per-bank timer shows up on the next legal or illegal command to that bank, as a verdict that flips between `cmd_ok` and `cmd_err` or as a wrong `err_code` one cycle after the command. A bad automatic-close schedule also shows on `bank_state` directly, in the cycle when the state should move from 3 to 2 and from 2 to 0. The directed sequences therefore probe each limit one cycle before and at its boundary, and read the state cycle by cycle through the automatic-close windows.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_CLOSING = 2'd2,
    BK_AUTOPRE = 2'd3
  } bank_st_e;

  typedef enum logic [3:0] {
    E_NONE      = 4'd0,
    E_NOT_IDLE  = 4'd1,
    E_TRC       = 4'd2,
    E_TRRD      = 4'd3,
    E_NOT_OPEN  = 4'd4,
    E_TRCD      = 4'd5,
    E_AP_BUSY   = 4'd6,
    E_TRAS      = 4'd7,
    E_AP_FULL   = 4'd8
  } err_e;

endpackage

// File: rtl/sbg_bank.sv
module sbg_bank
  import sbg_pkg::*;
#(
  parameter int T_RP    = 2,
  parameter int AGE_MAX = 7,
  parameter int AGE_W   = 3,
  parameter int WAIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_act,
  input  logic              do_pre,
  input  logic              do_ap,
  input  logic [WAIT_W-1:0] ap_wait,
  output bank_st_e          st_q,
  output logic [AGE_W-1:0]  age_q
);

  localparam logic [AGE_W-1:0]  AGE_SAT = AGE_W'(AGE_MAX);
  localparam logic [WAIT_W-1:0] RP_LOAD = WAIT_W'((T_RP > 1) ? T_RP - 1 : 0);
  localparam bank_st_e          PRE_ST  = (T_RP > 1) ? BK_CLOSING : BK_IDLE;

  bank_st_e          st_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [AGE_W-1:0]  age_d;
  logic              age_en;

  always_comb begin
    st_d   = st_q;
    wait_d = wait_q;
    age_en = (age_q != AGE_SAT);
    age_d  = age_q + 1'b1;
    unique case (st_q)
      BK_CLOSING: begin
        if (wait_q <= WAIT_W'(1)) st_d = BK_IDLE;
        else                      wait_d = wait_q - 1'b1;
      end
      BK_AUTOPRE: begin
        if (wait_q == '0) begin
          st_d   = PRE_ST;
          wait_d = RP_LOAD;
        end else begin
          wait_d = wait_q - 1'b1;
        end
      end
      default: ;
    endcase
    if (do_act) begin
      st_d   = BK_OPEN;
      age_en = 1'b1;
      age_d  = AGE_W'(1);
    end
    if (do_pre) begin
      st_d   = PRE_ST;
      wait_d = RP_LOAD;
    end
    if (do_ap) begin
      st_d   = BK_AUTOPRE;
      wait_d = ap_wait;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BK_IDLE;
      wait_q <= '0;
      age_q  <= AGE_SAT;
    end else begin
      st_q   <= st_d;
      wait_q <= wait_d;
      if (age_en) age_q <= age_d;
    end
  end

endmodule

// File: rtl/sbg_rules.sv
module sbg_rules
  import sbg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int AGE_W     = 3,
  parameter int RRD_W     = 2,
  parameter int T_RC      = 7,
  parameter int T_RAS     = 5,
  parameter int T_RCD     = 2,
  parameter int T_RRD     = 2,
  parameter int RD_DLY    = 4,
  parameter int WR_DLY    = 5,
  parameter bit FULL_PAGE = 1'b0
) (
  input  logic [2:0]                        op,
  input  logic [BANK_W-1:0]                 bank,
  input  logic                              a10,
  input  logic [NUM_BANKS-1:0][1:0]         st_vec,
  input  logic [NUM_BANKS-1:0][AGE_W-1:0]   age_vec,
  input  logic [RRD_W-1:0]                  rrd_age,
  output logic                              legal,
  output err_e                              code
);

  logic [1:0]       sel_st;
  logic [AGE_W-1:0] sel_age;
  logic             any_busy, any_short;
  int               ap_dly;

  always_comb begin
    sel_st    = st_vec[bank];
    sel_age   = age_vec[bank];
    ap_dly    = (op == OP_RD) ? RD_DLY : WR_DLY;
    any_busy  = 1'b0;
    any_short = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (a10 || (BANK_W'(i) == bank)) begin
        if (st_vec[i] == BK_AUTOPRE) any_busy = 1'b1;
        if (st_vec[i] == BK_OPEN && int'(age_vec[i]) < T_RAS) any_short = 1'b1;
      end
    end
    code = E_NONE;
    unique case (op)
      OP_ACT: begin
        if (sel_st != BK_IDLE)             code = E_NOT_IDLE;
        else if (int'(sel_age) < T_RC)     code = E_TRC;
        else if (int'(rrd_age) < T_RRD)    code = E_TRRD;
      end
      OP_RD, OP_WR: begin
        if (sel_st == BK_AUTOPRE)          code = E_AP_BUSY;
        else if (sel_st != BK_OPEN)        code = E_NOT_OPEN;
        else if (int'(sel_age) < T_RCD)    code = E_TRCD;
        else if (a10 && (int'(sel_age) + ap_dly < T_RAS)) code = E_TRAS;
        else if (a10 && FULL_PAGE)         code = E_AP_FULL;
      end
      OP_PRE: begin
        if (any_busy)                      code = E_AP_BUSY;
        else if (any_short)                code = E_TRAS;
      end
      default: ;
    endcase
    legal = (code == E_NONE);
  end

endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard
  import sbg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RC      = 7,
  parameter int T_RAS     = 5,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4,
  parameter bit FULL_PAGE = 1'b0,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_vld,
  input  logic [2:0]             cmd_op,
  input  logic [BANK_W-1:0]      cmd_bank,
  input  logic                   cmd_a10,
  output logic [2*NUM_BANKS-1:0] bank_state,
  output logic                   cmd_ok,
  output logic                   cmd_err,
  output logic [3:0]             err_code
);

  localparam int RD_DLY   = BURST_LEN;
  localparam int WR_DLY   = BURST_LEN - 1 + T_WR;
  localparam int AGE_MAX0 = (T_RC > T_RAS) ? T_RC : T_RAS;
  localparam int AGE_MAX  = (AGE_MAX0 > T_RCD) ? AGE_MAX0 : T_RCD;
  localparam int AGE_W    = $clog2(AGE_MAX + 1);
  localparam int RRD_W    = $clog2(T_RRD + 1);
  localparam int WAIT_M0  = (RD_DLY > WR_DLY) ? RD_DLY : WR_DLY;
  localparam int WAIT_MAX = (WAIT_M0 > T_RP) ? WAIT_M0 : T_RP;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam logic [WAIT_W-1:0] RD_LOAD = WAIT_W'(RD_DLY - 1);
  localparam logic [WAIT_W-1:0] WR_LOAD = WAIT_W'(WR_DLY - 1);
  localparam logic [RRD_W-1:0]  RRD_SAT = RRD_W'(T_RRD);

  logic [NUM_BANKS-1:0][1:0]       st_pk;
  logic [NUM_BANKS-1:0][AGE_W-1:0] age_pk;
  logic [RRD_W-1:0]                rrd_q, rrd_d;
  logic                            rrd_en;
  logic                            legal, accept;
  err_e                            code;
  logic                            ok_d, err_d;
  logic [3:0]                      code_d;

  sbg_rules #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .AGE_W(AGE_W), .RRD_W(RRD_W),
    .T_RC(T_RC), .T_RAS(T_RAS), .T_RCD(T_RCD), .T_RRD(T_RRD),
    .RD_DLY(RD_DLY), .WR_DLY(WR_DLY), .FULL_PAGE(FULL_PAGE)
  ) u_rules (
    .op(cmd_op), .bank(cmd_bank), .a10(cmd_a10),
    .st_vec(st_pk), .age_vec(age_pk), .rrd_age(rrd_q),
    .legal(legal), .code(code)
  );

  assign accept = cmd_vld && legal;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    bank_st_e         st_w;
    logic             hit, b_act, b_pre, b_ap;

    assign hit   = (cmd_bank == BANK_W'(i));
    assign b_act = accept && (cmd_op == OP_ACT) && hit;
    assign b_pre = accept && (cmd_op == OP_PRE) && (st_w == BK_OPEN) && (cmd_a10 || hit);
    assign b_ap  = accept && ((cmd_op == OP_RD) || (cmd_op == OP_WR)) && cmd_a10 && hit;

    sbg_bank #(
      .T_RP(T_RP), .AGE_MAX(AGE_MAX), .AGE_W(AGE_W), .WAIT_W(WAIT_W)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .do_act(b_act), .do_pre(b_pre), .do_ap(b_ap),
      .ap_wait((cmd_op == OP_RD) ? RD_LOAD : WR_LOAD),
      .st_q(st_w), .age_q(age_pk[i])
    );

    assign st_pk[i]            = st_w;
    assign bank_state[2*i +: 2] = st_w;
  end

  always_comb begin
    rrd_en = accept && (cmd_op == OP_ACT);
    rrd_d  = RRD_W'(1);
    if (!rrd_en && (rrd_q != RRD_SAT)) begin
      rrd_en = 1'b1;
      rrd_d  = rrd_q + 1'b1;
    end
    ok_d   = cmd_vld && legal;
    err_d  = cmd_vld && !legal;
    code_d = cmd_vld ? code : E_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_q    <= RRD_SAT;
      cmd_ok   <= 1'b0;
      cmd_err  <= 1'b0;
      err_code <= 4'd0;
    end else begin
      if (rrd_en) rrd_q <= rrd_d;
      cmd_ok   <= ok_d;
      cmd_err  <= err_d;
      err_code <= code_d;
    end
  end

endmodule

// File: rtl/sbg_checker.sv
module sbg_checker #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_vld,
  input logic [2:0]             cmd_op,
  input logic [BANK_W-1:0]      cmd_bank,
  input logic                   cmd_a10,
  input logic [2*NUM_BANKS-1:0] bank_state,
  input logic                   cmd_ok,
  input logic                   cmd_err,
  input logic [3:0]             err_code
);

  logic [1:0] tgt_st;
  assign tgt_st = bank_state[2*int'(cmd_bank) +: 2];

  a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> (cmd_ok ^ cmd_err));

  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> (!cmd_ok && !cmd_err));

  a_r2_code_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err == (err_code != 4'd0));

  a_r3_act_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 3'd1 && tgt_st != 2'd0) |=> (cmd_err && err_code == 4'd1));

  a_r6_access_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && (cmd_op == 3'd2 || cmd_op == 3'd3) && tgt_st != 2'd1) |=> cmd_err);

  a_r11_ap_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && (cmd_op == 3'd2 || cmd_op == 3'd3 || cmd_op == 3'd4) && tgt_st == 2'd3)
      |=> (cmd_err && err_code == 4'd6));

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank_chk
    logic [1:0] st_i;
    assign st_i = bank_state[2*i +: 2];

    a_r13_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == 2'd0 && !(cmd_vld && cmd_op == 3'd1 && int'(cmd_bank) == i))
        |=> st_i == 2'd0);

    a_r8_no_reopen_while_closing: assert property (@(posedge clk) disable iff (!rst_n)
      st_i == 2'd2 |=> st_i != 2'd1);
  end

endmodule

bind sdram_bank_guard sbg_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .cmd_a10(cmd_a10), .bank_state(bank_state),
  .cmd_ok(cmd_ok), .cmd_err(cmd_err), .err_code(err_code)
);

// File: tb/sdram_bank_guard_tb.sv
module sdram_bank_guard_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       vld;
  logic [2:0] op;
  logic [1:0] bank;
  logic       a10;
  logic [7:0] st_m, st_a;
  logic       ok_m, err_m, ok_a, err_a;
  logic [3:0] code_m, code_a;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_bank_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(vld), .cmd_op(op), .cmd_bank(bank),
    .cmd_a10(a10), .bank_state(st_m), .cmd_ok(ok_m), .cmd_err(err_m), .err_code(code_m)
  );

  sdram_bank_guard #(.T_RC(12), .T_RAS(8), .FULL_PAGE(1'b1)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .cmd_vld(vld), .cmd_op(op), .cmd_bank(bank),
    .cmd_a10(a10), .bank_state(st_a), .cmd_ok(ok_a), .cmd_err(err_a), .err_code(code_a)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic verdict_m(input string tag, input logic [3:0] exp_code);
    check({tag, " main ok"},   ok_m,   exp_code == 4'd0);
    check({tag, " main err"},  err_m,  exp_code != 4'd0);
    check({tag, " main code"}, code_m, exp_code);
  endtask

  task automatic verdict_a(input string tag, input logic [3:0] exp_code);
    check({tag, " alt ok"},   ok_a,   exp_code == 4'd0);
    check({tag, " alt err"},  err_a,  exp_code != 4'd0);
    check({tag, " alt code"}, code_a, exp_code);
  endtask

  function automatic logic [1:0] bst(input logic [7:0] v, input int b);
    return v[2*b +: 2];
  endfunction

  task automatic do_reset;
    vld = 1'b0; op = 3'd0; bank = 2'd0; a10 = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] o, input logic [1:0] b, input logic a);
    vld = 1'b1; op = o; bank = b; a10 = a;
    @(negedge clk);
    vld = 1'b0; op = 3'd0; a10 = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset();
    check("R1 reset state", st_m, 8'h00);
    check("R1 reset ok", ok_m, 1'b0);
    check("R1 reset err", err_m, 1'b0);
    check("R1 reset code", code_m, 4'd0);
    idle(1);
    check("R2 no verdict without valid", {ok_m, err_m}, 2'b00);
  endtask

  task automatic t_access;
    do_reset();
    issue(3'd1, 2'd0, 1'b0); verdict_m("R3 open bank0", 4'd0);
    issue(3'd2, 2'd0, 1'b0); verdict_m("R6 read before tRCD", 4'd5);
    issue(3'd3, 2'd0, 1'b0); verdict_m("R6 write at tRCD", 4'd0);
    issue(3'd2, 2'd3, 1'b0); verdict_m("R6 read idle bank", 4'd4);
    issue(3'd6, 2'd0, 1'b1); verdict_m("R2 code 6 no-op", 4'd0);
    check("R2 no-op keeps bank0 open", bst(st_m, 0), 2'd1);
    check("R13 idle bank3 untouched", bst(st_m, 3), 2'd0);
  endtask

  task automatic t_rrd;
    do_reset();
    issue(3'd1, 2'd0, 1'b0); verdict_m("R5 first open", 4'd0);
    issue(3'd1, 2'd1, 1'b0); verdict_m("R5 open other bank too soon", 4'd3);
    check("R13 rejected open leaves bank1 idle", bst(st_m, 1), 2'd0);
    issue(3'd1, 2'd1, 1'b0); verdict_m("R5 open other bank at tRRD", 4'd0);
    issue(3'd1, 2'd1, 1'b0); verdict_m("R3 open an open bank", 4'd1);
    check("R3 bank1 open", bst(st_m, 1), 2'd1);
  endtask

  task automatic t_close;
    do_reset();
    issue(3'd1, 2'd0, 1'b0);
    idle(2);
    issue(3'd4, 2'd0, 1'b0); verdict_m("R9 close at age 3", 4'd7);
    check("R13 bank0 stays open", bst(st_m, 0), 2'd1);
    issue(3'd4, 2'd0, 1'b0); verdict_m("R9 close at age 4", 4'd7);
    issue(3'd4, 2'd0, 1'b0); verdict_m("R9 close at tRAS", 4'd0);
    check("R8 bank0 closing", bst(st_m, 0), 2'd2);
    issue(3'd1, 2'd0, 1'b0); verdict_m("R8 open during tRP", 4'd1);
    issue(3'd1, 2'd0, 1'b0); verdict_m("R8 open after tRP", 4'd0);
    check("R8 bank0 reopened", bst(st_m, 0), 2'd1);
  endtask

  task automatic t_trc;
    do_reset();
    issue(3'd1, 2'd0, 1'b0);
    idle(7);
    issue(3'd4, 2'd0, 1'b0);
    verdict_m("R9 close at age 8", 4'd0);
    verdict_a("R9 close at alt tRAS", 4'd0);
    idle(1);
    issue(3'd1, 2'd0, 1'b0);
    verdict_m("R4 reopen at age 10 vs tRC 7", 4'd0);
    verdict_a("R4 reopen at age 10 vs tRC 12", 4'd2);
    check("R13 alt bank0 stays idle", bst(st_a, 0), 2'd0);
  endtask

  task automatic t_read_ap;
    do_reset();
    issue(3'd1, 2'd0, 1'b0);
    idle(1);
    issue(3'd2, 2'd0, 1'b1);
    verdict_m("R10 read auto-close", 4'd0);
    verdict_a("R9 auto-close before tRAS", 4'd7);
    check("R10 bank0 auto-close pending", bst(st_m, 0), 2'd3);
    issue(3'd3, 2'd0, 1'b0); verdict_m("R11 write during auto-close", 4'd6);
    issue(3'd4, 2'd0, 1'b0); verdict_m("R11 close during auto-close", 4'd6);
    check("R13 pending kept", bst(st_m, 0), 2'd3);
    idle(1);
    check("R10 still pending at t+3", bst(st_m, 0), 2'd3);
    idle(1);
    check("R10 closing from t+4", bst(st_m, 0), 2'd2);
    issue(3'd1, 2'd0, 1'b0); verdict_m("R8 open during auto tRP", 4'd1);
    check("R10 idle at t+6", bst(st_m, 0), 2'd0);
    issue(3'd1, 2'd0, 1'b0); verdict_m("R10 open after auto-close", 4'd0);
  endtask

  task automatic t_write_ap;
    do_reset();
    issue(3'd1, 2'd3, 1'b0);
    idle(1);
    issue(3'd3, 2'd3, 1'b1);
    verdict_m("R10 write auto-close", 4'd0);
    check("R10 bank3 pending", bst(st_m, 3), 2'd3);
    idle(4);
    check("R10 write pending at t+4", bst(st_m, 3), 2'd3);
    idle(1);
    check("R10 write closing from t+5", bst(st_m, 3), 2'd2);
    idle(1);
    check("R10 write idle after tDAL", bst(st_m, 3), 2'd0);
  endtask

  task automatic t_fullpage;
    do_reset();
    issue(3'd1, 2'd2, 1'b0);
    idle(3);
    issue(3'd2, 2'd2, 1'b1);
    verdict_m("R12 auto-close without full page", 4'd0);
    verdict_a("R12 auto-close with full page", 4'd8);
    check("R13 alt bank2 stays open", bst(st_a, 2), 2'd1);
  endtask

  task automatic t_close_all;
    do_reset();
    issue(3'd1, 2'd0, 1'b0);
    idle(1);
    issue(3'd1, 2'd2, 1'b0);
    idle(3);
    issue(3'd4, 2'd1, 1'b1); verdict_m("R9 close-all with young bank2", 4'd7);
    issue(3'd4, 2'd0, 1'b0); verdict_m("R7 single close bank0", 4'd0);
    check("R7 bank0 closing", bst(st_m, 0), 2'd2);
    check("R7 bank2 untouched", bst(st_m, 2), 2'd1);
    issue(3'd4, 2'd0, 1'b1); verdict_m("R7 close-all", 4'd0);
    check("R7 bank0 idle", bst(st_m, 0), 2'd0);
    check("R7 bank2 closing", bst(st_m, 2), 2'd2);
    issue(3'd4, 2'd1, 1'b0); verdict_m("R7 close idle bank1", 4'd0);
    check("R7 bank1 still idle", bst(st_m, 1), 2'd0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_access();
    t_rrd();
    t_close();
    t_trc();
    t_read_ap();
    t_write_ap();
    t_fullpage();
    t_close_all();
    done = 1'b1;
    finish_run();
  end

endmodule